// File: doc/BRIEF.md
# Hysteretic Lock Detector

This block watches a stream of signed phase-error samples, one per reference period, and decides whether a loop is locked. A sample counts as good when its magnitude is below a small threshold. The lock flag rises only after a long unbroken run of good samples. Once it is up, it falls only after a shorter unbroken run of bad samples. The gap between the two run lengths gives hysteresis, so a single noisy sample does not toggle the flag.

Samples arrive as a two's-complement word with a valid strobe. The input has no ready signal and the block never applies back-pressure. A sample presented with the strobe high is taken on that clock edge, and back-to-back valid samples are each counted. Cycles with the strobe low carry no sample.

Two separate run counters do the work. The acquire counter runs only while unlocked. The release counter runs only while locked. Both are cleared whenever the flag changes state.

Top module: `lockdet_top`

## Requirements
- R1: After reset, with `rst_n` low then released, `lock_o` is 0 and both run counts are zero. Lock therefore needs a full acquire run.
- R2: A sample is good when the absolute value of `err_sample`, read as two's complement, is strictly less than THRESH (default 4). With the defaults, -3 to +3 are good and +4 and -4 are bad.
- R3: While unlocked, `lock_o` becomes 1 at the clock edge that takes the ACQ_RUN-th (default 16) consecutive good valid sample. It is visible after that edge. Samples on consecutive cycles each count.
- R4: While unlocked, a bad valid sample restarts the acquire run from zero.
- R5: While locked, `lock_o` becomes 0 at the clock edge that takes the REL_RUN-th (default 4) consecutive bad valid sample.
- R6: While locked, a good valid sample restarts the release run from zero.
- R7: A cycle with `err_valid` low has no effect on the lock flag or on either run, whatever `err_sample` holds.
- R8: Both runs are cleared on every change of `lock_o`. After losing lock, a full ACQ_RUN of good samples is needed again. After gaining lock, a full REL_RUN of bad samples is needed to lose it.
- R9: The most negative error value (0x8000 at 16 bits) is bad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_valid | input | 1 | High when `err_sample` holds a sample to take this cycle |
| err_sample | input | ERR_W | Signed error sample, two's complement |
| lock_o | output | 1 | Registered lock flag |

## Verification
The run counters are visible only through `lock_o`, so a wrong count shows up as the flag moving on the wrong sample. If a counter fails to clear or to restart, the flag rises or falls one or more samples early. This is caught on the very sample where the flag should still hold. If a counter leaks across a state change, the next acquire or release is shortened, and the error appears within 16 samples of that change. A wrong magnitude test at the threshold or at the most negative value changes which sample completes a run, so it also shows up within one run length.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;
  localparam int DEF_ERR_W   = 16;
  localparam int DEF_THRESH  = 4;
  localparam int DEF_ACQ_RUN = 16;
  localparam int DEF_REL_RUN = 4;

  typedef enum logic {ST_HUNT = 1'b0, ST_HELD = 1'b1} lock_st_e;
endpackage

// File: rtl/lockdet_range.sv
module lockdet_range #(
  parameter int W      = 16,
  parameter int THRESH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] err,
  output logic         in_rng
);
  localparam logic [W-1:0] THR_V    = W'(THRESH);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] mag;

  // Unsigned negation yields the true magnitude even for the most negative value
  always_comb begin
    mag    = err[W-1] ? (~err + 1'b1) : err;
    in_rng = (mag < THR_V);
  end

  // R9
  most_neg_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err == MOST_NEG) |-> !in_rng);
endmodule

// File: rtl/lockdet_runctr.sv
module lockdet_runctr #(
  parameter int RUN = 16,
  localparam int CW = (RUN > 2) ? $clog2(RUN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] count,
  output logic          hit
);
  localparam logic [CW-1:0] LAST = CW'(RUN - 1);

  assign hit = inc && (count == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= count + 1'b1;
  end
endmodule

// File: rtl/lockdet_top.sv
module lockdet_top #(
  parameter int ERR_W   = lockdet_pkg::DEF_ERR_W,
  parameter int THRESH  = lockdet_pkg::DEF_THRESH,
  parameter int ACQ_RUN = lockdet_pkg::DEF_ACQ_RUN,
  parameter int REL_RUN = lockdet_pkg::DEF_REL_RUN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_valid,
  input  logic [ERR_W-1:0] err_sample,
  output logic             lock_o
);
  import lockdet_pkg::*;

  localparam int ACW = (ACQ_RUN > 2) ? $clog2(ACQ_RUN) : 1;
  localparam int RCW = (REL_RUN > 2) ? $clog2(REL_RUN) : 1;

  lock_st_e st;
  logic in_rng, held;
  logic acq_inc, acq_clr, acq_hit;
  logic rel_inc, rel_clr, rel_hit;
  logic [ACW-1:0] acq_cnt;
  logic [RCW-1:0] rel_cnt;

  assign held = (st == ST_HELD);

  lockdet_range #(.W(ERR_W), .THRESH(THRESH)) rng_i (
    .clk(clk), .rst_n(rst_n), .err(err_sample), .in_rng(in_rng)
  );

  // Each counter runs only in its own state; any state change clears both
  always_comb begin
    acq_inc = err_valid && !held && in_rng;
    rel_inc = err_valid &&  held && !in_rng;
    acq_clr = (err_valid && !held && !in_rng) || acq_hit || rel_hit;
    rel_clr = (err_valid &&  held &&  in_rng) || acq_hit || rel_hit;
  end

  lockdet_runctr #(.RUN(ACQ_RUN)) acq_i (
    .clk(clk), .rst_n(rst_n), .clr(acq_clr), .inc(acq_inc),
    .count(acq_cnt), .hit(acq_hit)
  );

  lockdet_runctr #(.RUN(REL_RUN)) rel_i (
    .clk(clk), .rst_n(rst_n), .clr(rel_clr), .inc(rel_inc),
    .count(rel_cnt), .hit(rel_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       st <= ST_HUNT;
    else if (acq_hit) st <= ST_HELD;
    else if (rel_hit) st <= ST_HUNT;
  end

  assign lock_o = held;

  // R3
  rise_on_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(err_valid && in_rng));
  // R5
  fall_on_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_o) |-> $past(err_valid && !in_rng));
  // R7
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_valid |=> $stable(lock_o));
  // R8
  acq_idle_when_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |-> (acq_cnt == '0));
  // R8
  rel_idle_when_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_o |-> (rel_cnt == '0));
endmodule

// File: tb/lockdet_top_tb_top.sv
module lockdet_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic err_valid = 1'b0;
  logic [15:0] err_sample = '0;
  logic lock_o;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lockdet_top dut_i (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid),
    .err_sample(err_sample), .lock_o(lock_o)
  );

  task automatic check(input logic exp, input string req);
    n_run++;
    if (lock_o !== exp) begin
      n_fail++;
      $display("FAIL %s: lock_o actual %b expected %b", req, lock_o, exp);
    end
  endtask

  // Drive on the falling edge; return 1 ns after the rising edge that takes it
  task automatic push(input int e, input logic v);
    @(negedge clk);
    err_sample = 16'(e);
    err_valid  = v;
    @(posedge clk);
    #1;
  endtask

  task automatic push_n(input int e, input int n);
    for (int i = 0; i < n; i++) push(e, 1'b1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; err_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check(1'b0, "R1 reset");
  endtask

  task automatic t_acquire();
    do_reset();
    push_n(0, 15);  check(1'b0, "R3 after 15 good");
    push(0, 1'b1);  check(1'b1, "R3 16th good");
  endtask

  task automatic t_range();
    do_reset();
    for (int i = 0; i < 15; i++) push((i % 2) ? 3 : -3, 1'b1);
    check(1'b0, "R2 15 samples of +-3");
    push(-3, 1'b1); check(1'b1, "R2 -3 is good");
    do_reset();
    push_n(0, 15); push(4, 1'b1); check(1'b0, "R2 +4 is bad");
    push_n(1, 15); push(-4, 1'b1); check(1'b0, "R2 -4 is bad");
  endtask

  task automatic t_restart();
    do_reset();
    push_n(2, 10); push(50, 1'b1);
    push_n(2, 15); check(1'b0, "R4 run restarted");
    push(2, 1'b1); check(1'b1, "R4 full run after bad");
  endtask

  task automatic t_most_neg();
    do_reset();
    push_n(0, 15); push(-32768, 1'b1);
    push_n(0, 15); check(1'b0, "R9 most negative is bad");
    push(0, 1'b1); check(1'b1, "R9 relock");
  endtask

  task automatic t_valid_gap();
    do_reset();
    push_n(0, 15);
    for (int i = 0; i < 5; i++) push(100, 1'b0);
    check(1'b0, "R7 idle while hunting");
    push(0, 1'b1); check(1'b1, "R7 idle cycles ignored");
    push_n(9, 3);
    for (int i = 0; i < 5; i++) push(0, 1'b0);
    check(1'b1, "R7 idle while held");
    push(9, 1'b1); check(1'b0, "R5 4th bad with idle gap");
  endtask

  task automatic t_release();
    do_reset();
    push_n(0, 16); check(1'b1, "R5 locked");
    push_n(-7, 3); check(1'b1, "R5 after 3 bad");
    push(-7, 1'b1); check(1'b0, "R5 4th bad");
  endtask

  task automatic t_hold_restart();
    do_reset();
    push_n(0, 16);
    push_n(8, 3); push(1, 1'b1); push_n(8, 3);
    check(1'b1, "R6 release run restarted");
    push(8, 1'b1); check(1'b0, "R6 full bad run");
  endtask

  task automatic t_clear_on_change();
    do_reset();
    push_n(0, 16); push_n(20, 4); check(1'b0, "R8 unlocked");
    push_n(0, 15); check(1'b0, "R8 acquire restarts from zero");
    push(0, 1'b1); check(1'b1, "R8 relock on 16th");
    push_n(20, 3); check(1'b1, "R8 release restarts from zero");
    push(20, 1'b1); check(1'b0, "R8 unlock on 4th");
  endtask

  initial begin
    t_acquire();
    t_range();
    t_restart();
    t_most_neg();
    t_valid_gap();
    t_release();
    t_hold_restart();
    t_clear_on_change();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule